// File: doc/BRIEF.md
# Power domain state controller

This block manages the power level of one domain that owns four memory banks. Software programs a target level, a per-bank retention choice and a "go deeper while asleep" request through a small 32-bit register bus. An activity input from the domain itself asks for the fully active level. A sequencer compares the level it should be at (the goal) with the level it is at, and runs a timed transition whenever the two differ. When that transition ends, it updates the current level, the logic-power flag and the per-bank states in the same cycle.

Power levels use one code for both target and status: 0 = OFF, 1 = RETENTION, 2 = IDLE (powered but not active), 3 = ACTIVE. The goal is ACTIVE whenever the activity input is high. If the domain is powered (IDLE or ACTIVE) and the activity input is low, the goal is the target, with a target of 3 mapped to IDLE. If the domain is asleep (OFF or RETENTION), the goal stays at the current level. The one exception is a set deeper request with a target numerically below the current level, in which case the goal is that target.

The sequencer has two named states. SEQ_STEADY takes the transition "goal differs" to SEQ_SWITCH, latching the goal as the destination. SEQ_SWITCH takes the transition "count done" back to SEQ_STEADY and commits the destination. Control fields reset on either reset input. Status fields reset only on the cold reset.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After cold reset the control word (offset 0x0) reads 0x00FF0003 and the status word (offset 0x4) reads 0x03000FF7: level 3, logic bit 1, every bank code 3, in-transition 0, last level 3.
- R2: Control layout: bits [1:0] target (read/write), bit 2 logic retention (reads 0, meaning logic is off when retained), bit 4 deeper request, bits [10:8] retention choice of banks 0..2 (read/write), bit 11 bank 3 retention (reads 0 whatever is written), bits [23:16] four 2-bit on-level codes reading 3 each, all other bits 0.
- R3: With the activity input high the domain moves to or stays at ACTIVE. When the activity input drops from ACTIVE, the domain moves to the target, with target 3 giving IDLE (2). While powered, a new target is followed without any deeper request.
- R4: The in-transition flag (status bit 20 and `in_trans_o`) is 1 for exactly TRANS_CYCLES cycles, starting on the edge after the goal first differs from the current level. The current level changes only on the edge where the flag falls.
- R5: Status layout: [1:0] level, bit 2 logic on, bank i code at bits [2i+5:2i+4], bit 20 in-transition, [25:24] last level. On commit: OFF sets every bank code to 0. RETENTION sets bank i to 1 if its retention bit is 1 and to 0 otherwise. IDLE and ACTIVE set every bank to 3. The logic bit is 1 only for IDLE and ACTIVE.
- R6: While asleep, a new target with the deeper request clear, or a target not below the current level, starts no transition and leaves a set deeper request in place.
- R7: While asleep, a set deeper request with a lower target moves the domain to that target without passing through a powered level, and the request bit reads 0 after the commit.
- R8: The deeper request reads 0 one cycle after any cycle in which the level is IDLE or ACTIVE, even if just written with 1.
- R9: The last-level field takes each committed level. A bus write to the status word with bits [25:24] = 3 sets it to 3; any other written value, and every other status bit, is ignored.
- R10: The warm reset returns the control word to its reset value and leaves the status word unchanged.
- R11: Offsets other than 0x0 and 0x4 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Active-low cold reset, clears control and status |
| warm_rst_n | input | 1 | Active-low warm reset, clears control only |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dom_active | input | 1 | Domain activity, high asks for ACTIVE |
| pwr_state_o | output | 2 | Current power level code |
| in_trans_o | output | 1 | High while a transition runs |

## Verification
A register write lands on the edge that samples the strobe, so a read on the following falling edge already shows it. The deeper-request clear is also due by then. A goal change made by a write is seen one edge after that write, and one made by the activity input is seen on the edge that samples it. The flag then stays high for TRANS_CYCLES edges, and level, logic bit, bank codes and last level all move on the edge where it falls. The bench drives every input on a falling edge. In the timing test it samples the flag and the level on each following falling edge. Elsewhere it waits TRANS_CYCLES+3 cycles before comparing whole words against a requirement-based model.

// File: rtl/pwr_domain_pkg.sv
package pwr_domain_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Power level code, shared by the target and the status fields
    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_RET    = 2'd1,
        PS_IDLE   = 2'd2,
        PS_ACTIVE = 2'd3
    } pstate_e;

    typedef enum logic {
        SEQ_STEADY = 1'b0,
        SEQ_SWITCH = 1'b1
    } seq_e;

    localparam logic [1:0] BANK_OFF  = 2'd0;
    localparam logic [1:0] BANK_KEEP = 2'd1;
    localparam logic [1:0] BANK_ON   = 2'd3;

    localparam int CTRL_OFS = 0;
    localparam int STAT_OFS = 4;

    // control word fields
    localparam int F_TARGET_LSB   = 0;
    localparam int F_LOGICRET_BIT = 2;
    localparam int F_DEEPER_BIT   = 4;
    localparam int F_RET_LSB      = 8;
    localparam int F_ONLVL_LSB    = 16;
    // status word fields
    localparam int F_CUR_LSB      = 0;
    localparam int F_LOGIC_BIT    = 2;
    localparam int F_BANK_LSB     = 4;
    localparam int F_BUSY_BIT     = 20;
    localparam int F_LAST_LSB     = 24;

    function automatic logic is_awake(input pstate_e s);
        return s[1];
    endfunction

    // Level the domain should settle at
    function automatic pstate_e pick_goal(input logic active, input pstate_e target,
                                          input pstate_e cur, input logic deeper);
        pstate_e g;
        if (active)
            g = PS_ACTIVE;
        else if (is_awake(cur))
            g = (target == PS_ACTIVE) ? PS_IDLE : target;
        else if (deeper && (target < cur))
            g = target;
        else
            g = cur;
        return g;
    endfunction
endpackage

// File: rtl/pwr_domain_ctrl_regs.sv
module pwr_domain_ctrl_regs
    import pwr_domain_pkg::*;
#(
    parameter int                   NUM_BANKS   = 4,
    parameter logic [NUM_BANKS-1:0] RO_RET_MASK = NUM_BANKS'(1) << (NUM_BANKS - 1)
) (
    input  logic                 clk,
    input  logic                 cold_rst_n,
    input  logic                 warm_rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           tgt_wr,
    input  logic                 deeper_wr,
    input  logic [NUM_BANKS-1:0] ret_wr,
    input  logic                 awake,
    input  logic                 commit,
    output pstate_e              target_o,
    output logic                 deeper_o,
    output logic [NUM_BANKS-1:0] ret_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic ctrl_rst_n;
    assign ctrl_rst_n = cold_rst_n & warm_rst_n;

    always_ff @(posedge clk or negedge ctrl_rst_n) begin
        if (!ctrl_rst_n) begin
            target_o <= PS_ACTIVE;
        end else if (wr_en) begin
            target_o <= pstate_e'(tgt_wr);
        end
    end

    // clear on commit or while powered wins over a write
    always_ff @(posedge clk or negedge ctrl_rst_n) begin
        if (!ctrl_rst_n) begin
            deeper_o <= 1'b0;
        end else if (commit || awake) begin
            deeper_o <= 1'b0;
        end else if (wr_en) begin
            deeper_o <= deeper_wr;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ret
        if (RO_RET_MASK[b]) begin : g_fixed
            logic unused_bit;
            assign unused_bit = ret_wr[b];
            assign ret_o[b]   = 1'b0;
        end else begin : g_rw
            logic ret_q;
            always_ff @(posedge clk or negedge ctrl_rst_n) begin
                if (!ctrl_rst_n) begin
                    ret_q <= 1'b0;
                end else if (wr_en) begin
                    ret_q <= ret_wr[b];
                end
            end
            assign ret_o[b] = ret_q;
        end
    end
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pwr_domain_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int TRANS_CYCLES = 4
) (
    input  logic                   clk,
    input  logic                   cold_rst_n,
    input  logic                   dom_active,
    input  pstate_e                target,
    input  logic                   deeper,
    input  logic [NUM_BANKS-1:0]   ret,
    input  logic                   last_wr,
    input  logic [1:0]             last_wdata,
    output pstate_e                state_o,
    output logic [2*NUM_BANKS-1:0] bank_st_o,
    output logic                   logic_on_o,
    output logic                   busy_o,
    output pstate_e                last_o,
    output logic                   commit_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int              CNT_W   = (TRANS_CYCLES > 1) ? $clog2(TRANS_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(TRANS_CYCLES - 1);

    seq_e                   seq_q, seq_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    pstate_e                dest_q, dest_d;
    pstate_e                goal;
    logic [2*NUM_BANKS-1:0] bank_next;

    assign goal   = pick_goal(dom_active, target, state_o, deeper);
    assign busy_o = (seq_q == SEQ_SWITCH);

    // next-state and strobe process
    always_comb begin
        seq_d    = seq_q;
        cnt_d    = cnt_q;
        dest_d   = dest_q;
        commit_o = 1'b0;
        unique case (seq_q)
            SEQ_STEADY: begin
                if (goal != state_o) begin
                    seq_d  = SEQ_SWITCH;
                    cnt_d  = '0;
                    dest_d = goal;
                end
            end
            SEQ_SWITCH: begin
                if (cnt_q == CNT_END) begin
                    seq_d    = SEQ_STEADY;
                    commit_o = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: seq_d = SEQ_STEADY;
        endcase
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_next[2*b +: 2] = (dest_q == PS_OFF) ? BANK_OFF :
                                     (dest_q == PS_RET) ? (ret[b] ? BANK_KEEP : BANK_OFF) :
                                                          BANK_ON;
    end

    // state register process, cold reset only
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            seq_q      <= SEQ_STEADY;
            cnt_q      <= '0;
            dest_q     <= PS_ACTIVE;
            state_o    <= PS_ACTIVE;
            bank_st_o  <= {NUM_BANKS{BANK_ON}};
            logic_on_o <= 1'b1;
            last_o     <= PS_ACTIVE;
        end else begin
            seq_q  <= seq_d;
            cnt_q  <= cnt_d;
            dest_q <= dest_d;
            if (commit_o) begin
                state_o    <= dest_q;
                bank_st_o  <= bank_next;
                logic_on_o <= is_awake(dest_q);
                last_o     <= dest_q;
            end else if (last_wr && (last_wdata == 2'b11)) begin
                last_o <= PS_ACTIVE;
            end
        end
    end
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
    import pwr_domain_pkg::*;
#(
    parameter int                   NUM_BANKS    = 4,
    parameter int                   TRANS_CYCLES = 4,
    parameter int                   ADDR_W       = 4,
    parameter logic [NUM_BANKS-1:0] RO_RET_MASK  = NUM_BANKS'(1) << (NUM_BANKS - 1)
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              warm_rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dom_active,
    output logic [1:0]        pwr_state_o,
    output logic              in_trans_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    logic                   sel_ctrl, sel_stat, wr_ctrl, wr_stat;
    pstate_e                target_q, cur_state, last_state;
    logic                   deeper_q, logic_on, busy, commit;
    logic [NUM_BANKS-1:0]   ret_q;
    logic [2*NUM_BANKS-1:0] bank_st;
    logic                   unused_wbits;

    assign sel_ctrl     = (bus_addr == A_CTRL);
    assign sel_stat     = (bus_addr == A_STAT);
    assign wr_ctrl      = bus_wr && sel_ctrl;
    assign wr_stat      = bus_wr && sel_stat;
    assign unused_wbits = ^bus_wdata;

    pwr_domain_ctrl_regs #(
        .NUM_BANKS  (NUM_BANKS),
        .RO_RET_MASK(RO_RET_MASK)
    ) regs_i (
        .clk       (clk),
        .cold_rst_n(cold_rst_n),
        .warm_rst_n(warm_rst_n),
        .wr_en     (wr_ctrl),
        .tgt_wr    (bus_wdata[F_TARGET_LSB +: 2]),
        .deeper_wr (bus_wdata[F_DEEPER_BIT]),
        .ret_wr    (bus_wdata[F_RET_LSB +: NUM_BANKS]),
        .awake     (is_awake(cur_state)),
        .commit    (commit),
        .target_o  (target_q),
        .deeper_o  (deeper_q),
        .ret_o     (ret_q)
    );

    pwr_domain_seq #(
        .NUM_BANKS   (NUM_BANKS),
        .TRANS_CYCLES(TRANS_CYCLES)
    ) seq_i (
        .clk       (clk),
        .cold_rst_n(cold_rst_n),
        .dom_active(dom_active),
        .target    (target_q),
        .deeper    (deeper_q),
        .ret       (ret_q),
        .last_wr   (wr_stat),
        .last_wdata(bus_wdata[F_LAST_LSB +: 2]),
        .state_o   (cur_state),
        .bank_st_o (bank_st),
        .logic_on_o(logic_on),
        .busy_o    (busy),
        .last_o    (last_state),
        .commit_o  (commit)
    );

    assign pwr_state_o = cur_state;
    assign in_trans_o  = busy;

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[F_TARGET_LSB +: 2]  = target_q;
            bus_rdata[F_LOGICRET_BIT]     = 1'b0;
            bus_rdata[F_DEEPER_BIT]       = deeper_q;
            for (int b = 0; b < NUM_BANKS; b++) begin
                bus_rdata[F_RET_LSB + b]         = ret_q[b];
                bus_rdata[F_ONLVL_LSB + 2*b +: 2] = BANK_ON;
            end
        end else if (sel_stat) begin
            bus_rdata[F_CUR_LSB +: 2]             = cur_state;
            bus_rdata[F_LOGIC_BIT]                = logic_on;
            bus_rdata[F_BANK_LSB +: 2*NUM_BANKS]  = bank_st;
            bus_rdata[F_BUSY_BIT]                 = busy;
            bus_rdata[F_LAST_LSB +: 2]            = last_state;
        end
    end
endmodule

// File: rtl/pwr_domain_ctrl_chk.sv
module pwr_domain_ctrl_chk #(
    parameter int NUM_BANKS    = 4,
    parameter int TRANS_CYCLES = 4
) (
    input logic                   clk,
    input logic                   cold_rst_n,
    input logic [1:0]             state,
    input logic                   busy,
    input logic                   deeper,
    input logic [2*NUM_BANKS-1:0] bank_st,
    input logic                   logic_on
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [15:0] run_cnt;

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n)  run_cnt <= '0;
        else if (busy)    run_cnt <= run_cnt + 16'd1;
        else              run_cnt <= '0;
    end

    assert_level_moves_at_end_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !$stable(state) |-> $fell(busy));

    assert_window_length_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $fell(busy) |-> (run_cnt == 16'(TRANS_CYCLES)));

    assert_off_banks_R5: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (state == 2'd0) |-> ((bank_st == '0) && !logic_on));

    assert_powered_banks_R5: assert property (@(posedge clk) disable iff (!cold_rst_n)
        state[1] |-> ((bank_st == '1) && logic_on));

    assert_deeper_clear_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        state[1] |=> !deeper);
endmodule

bind pwr_domain_ctrl pwr_domain_ctrl_chk #(
    .NUM_BANKS   (NUM_BANKS),
    .TRANS_CYCLES(TRANS_CYCLES)
) chk_i (
    .clk       (clk),
    .cold_rst_n(cold_rst_n),
    .state     (cur_state),
    .busy      (busy),
    .deeper    (deeper_q),
    .bank_st   (bank_st),
    .logic_on  (logic_on)
);

// File: tb/pwr_domain_ctrl_tb_top.sv
module pwr_domain_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TC = 4;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        dom_active = 1'b1;
    logic [1:0]  pwr_state_o;
    logic        in_trans_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [1:0] m_cur, m_target, m_last;
    logic       m_lpsc, m_act;
    logic [2:0] m_ret;
    logic [7:0] m_banks;

    always #5 clk = ~clk;

    pwr_domain_ctrl #(.TRANS_CYCLES(TC)) dut_i (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .warm_rst_n (warm_rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dom_active (dom_active),
        .pwr_state_o(pwr_state_o),
        .in_trans_o (in_trans_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] stat_word(input logic [1:0] cur, input logic [7:0] banks,
                                              input logic [1:0] last);
        return (32'(last) << 24) | (32'(banks) << 4) | (32'(cur[1]) << 2) | 32'(cur);
    endfunction

    function automatic logic [31:0] ctrl_word(input logic [1:0] tgt, input logic lp,
                                              input logic [2:0] ret);
        return 32'h00FF_0000 | (32'(ret) << 8) | (32'(lp) << 4) | 32'(tgt);
    endfunction

    function automatic logic [7:0] banks_for(input logic [1:0] lvl, input logic [2:0] ret);
        logic [7:0] r;
        for (int b = 0; b < 4; b++) begin
            if (lvl == 2'd0)      r[2*b +: 2] = 2'd0;
            else if (lvl == 2'd1) r[2*b +: 2] = (b < 3 && ret[b]) ? 2'd1 : 2'd0;
            else                  r[2*b +: 2] = 2'd3;
        end
        return r;
    endfunction

    function automatic logic [1:0] goal_ref(input logic act, input logic [1:0] tgt,
                                            input logic [1:0] cur, input logic lp);
        if (act) return 2'd3;
        if (cur >= 2'd2) return (tgt == 2'd3) ? 2'd2 : tgt;
        if (lp && tgt < cur) return tgt;
        return cur;
    endfunction

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        idle(3);
        cold_rst_n = 1'b1;
        idle(2);

        // R1 reset values
        rd(4'h0, v); check("R1 ctrl reset", v, 32'h00FF_0003);
        rd(4'h4, v); check("R1 status reset", v, 32'h0300_0FF7);
        check("R1 in_trans reset", 32'(in_trans_o), 32'd0);

        // R2 layout, R8 clear while powered
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R2 ctrl field mask (R8 deeper clear)", v, 32'h00FF_0703);

        // R3 active keeps ACTIVE
        wr(4'h0, 32'h0000_0501);
        idle(TC + 2);
        check("R3 stay active", 32'(pwr_state_o), 32'd3);

        // R4 timing of the drop to RETENTION
        @(negedge clk); dom_active = 1'b0;
        for (int k = 1; k <= TC; k++) begin
            @(negedge clk);
            check("R4 flag during window", 32'(in_trans_o), 32'd1);
            check("R4 level held in window", 32'(pwr_state_o), 32'd3);
        end
        @(negedge clk);
        check("R4 flag after window", 32'(in_trans_o), 32'd0);
        check("R4 level after window", 32'(pwr_state_o), 32'd1);
        rd(4'h4, v); check("R5 retention bank codes", v, 32'h0100_0111);

        // R6 asleep, no deeper request
        wr(4'h0, 32'h0000_0000);
        idle(TC + 3);
        check("R6 no move without request", 32'(pwr_state_o), 32'd1);

        // R7 deeper request to OFF
        wr(4'h0, 32'h0000_0010);
        idle(TC + 3);
        rd(4'h4, v); check("R7 moved to OFF (R5 banks off)", v, 32'h0000_0000);
        rd(4'h0, v); check("R7 request cleared", v, 32'h00FF_0000);

        // R6 shallower target with request
        wr(4'h0, 32'h0000_0011);
        idle(TC + 3);
        check("R6 shallower ignored", 32'(pwr_state_o), 32'd0);
        rd(4'h0, v); check("R6 request kept", v, 32'h00FF_0011);

        // R9 last-level writes
        wr(4'h4, 32'hFEFF_FFFF & 32'h02FF_FFFF);
        rd(4'h4, v); check("R9 write 2 ignored", v, 32'h0000_0000);
        wr(4'h4, 32'h0300_0000);
        rd(4'h4, v); check("R9 write 3 sets", v, 32'h0300_0000);

        // R10 warm reset
        @(negedge clk); warm_rst_n = 1'b0;
        @(negedge clk); warm_rst_n = 1'b1;
        rd(4'h0, v); check("R10 ctrl back to reset", v, 32'h00FF_0003);
        rd(4'h4, v); check("R10 status kept", v, 32'h0300_0000);

        // R3 wake and drop to IDLE
        @(negedge clk); dom_active = 1'b1;
        idle(TC + 3);
        rd(4'h4, v); check("R3 wake to active", v, 32'h0300_0FF7);
        @(negedge clk); dom_active = 1'b0;
        idle(TC + 3);
        rd(4'h4, v); check("R3 drop to idle", v, 32'h0200_0FF6);

        // R11 unmapped offset
        rd(4'h8, v); check("R11 unmapped read", v, 32'h0);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R11 ctrl untouched", v, 32'h00FF_0003);
        rd(4'h4, v); check("R11 status untouched", v, 32'h0200_0FF6);

        // random phase
        m_cur = 2'd2; m_target = 2'd3; m_lpsc = 1'b0; m_ret = 3'd0;
        m_last = 2'd2; m_banks = 8'hFF; m_act = 1'b0;
        for (int it = 0; it < 60; it++) begin
            int op;
            logic [31:0] d;
            logic [1:0] g;
            op = int'($urandom % 3);
            d  = $urandom;
            if (op == 0) begin
                m_act = d[0];
                @(negedge clk); dom_active = d[0];
            end else if (op == 1) begin
                m_target = d[1:0]; m_lpsc = d[4]; m_ret = d[10:8];
                wr(4'h0, d);
            end else begin
                if (d[25:24] == 2'd3) m_last = 2'd3;
                wr(4'h4, d);
            end
            if (m_cur >= 2'd2) m_lpsc = 1'b0;
            g = goal_ref(m_act, m_target, m_cur, m_lpsc);
            if (g != m_cur) begin
                m_cur = g; m_lpsc = 1'b0;
                m_banks = banks_for(g, m_ret);
                m_last = g;
            end
            idle(TC + 3);
            rd(4'h4, v); check("R3 R5 R7 R9 random status", v, stat_word(m_cur, m_banks, m_last));
            rd(4'h0, v); check("R2 R8 random ctrl", v, ctrl_word(m_target, m_lpsc, m_ret));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule